// File: doc/BRIEF.md
# UART Register Front End with Receive Holding Buffer

This block is the software-visible side of a simple UART. A word-addressed bus reads and writes 16-bit registers. Several control registers and a set of storage-only registers (baud, FIFO-control and millisecond-tick settings) read back what was written. Two status registers have bits that are cleared by writing 1. Receive data lands in a one-character holding buffer. Transmit bytes pass straight through to a byte output with a one-cycle strobe. Serial framing, baud generation and real FIFOs belong to other blocks.

The receive side offers a byte-valid input and a break-event input, and reports a ready output that is high while the holding buffer is empty. Software empties the buffer by reading the receive-data register, and that read also updates the status registers. Writing a control-register-2 value whose bit 0 is 0 performs a soft reset of the status, control and buffer state. A single registered level interrupt combines the receive-ready and transmit-ready status with their enables.

Top module: `uart_regfront`

## Requirements
- R1: After the power-on reset, reads return CR1 (0x20) = 0x0001, CR2 (0x21) = 0x0004, CR3 (0x22) = 0x0700, SR1 (0x25) = 0x6040, SR2 (0x26) = 0x4028, test register (0x2D) = 0x0060, baud modulator (0x2A) = 0, baud count (0x2B) = 0x0004, FIFO control (0x24) = 0, one-ms (0x2C) = 0, and receive data (0x00) = 0x4000.
- R2: Read data appears on `rd_data` in the cycle after `rd_en`. A read of offset 0x00 returns the buffer contents. When the buffer is full, the read also sets bit 15 of the returned value and empties the buffer: SR1 bit 9 clears, SR2 bit 0 clears and test bit 5 sets.
- R3: A byte on `rx_valid` is taken only while `rx_ready` is high, and `rx_ready` is the inverse of SR1 bit 9. A taken byte is stored zero-extended, sets SR1 bit 9 and SR2 bit 0, and clears test bit 5. Bytes offered while the buffer is full are dropped.
- R4: A taken `rx_break` stores 0x0800 (bit 11 set) through the same path. It wins over a byte offered in the same cycle.
- R5: `irq` is registered. It equals (SR1[9] & CR1[9]) | (SR1[13] & CR1[13] & CR1[6]), computed from the state of the previous cycle.
- R6: A write to offset 0x10 sends the low byte on `tx_byte` with a one-cycle `tx_valid` in the next cycle, but only while CR2 bit 2 is 1. Otherwise the write is dropped. SR1 bit 13 stays 1 throughout.
- R7: Writing 1 clears only SR1 bits in mask 0x9DB0 and SR2 bits in mask 0xBDD6. All other written status bits have no effect.
- R8: A write to CR2 with bit 0 = 0 restores the R1 values except for the following: CR1 becomes 0, CR2 stores the written value with bit 0 forced to 1, and FIFO control and one-ms keep their contents.
- R9: CR1, CR3, FIFO control, baud modulator and one-ms store and return the written 16 bits. A write to offset 0x29 loads the baud-count register read at 0x2B, while 0x29 itself reads 0.
- R10: Writes to CR4 (0x23) and the test register (0x2D) have no effect. CR4 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Word offset of the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Word offset of the read |
| rd_data | output | 16 | Registered read data, valid one cycle after rd_en |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event offered |
| rx_ready | output | 1 | Holding buffer empty, receive accepted |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is an interaction between the buffer and other events: a full buffer refusing a second byte, or a break arriving together with a byte. The bench fills the buffer first, offers a second byte while `rx_ready` is low, and then reads. It checks that the first byte comes back with bit 15 set and that a second read returns the same byte without bit 15. For the soft reset, the bench loads the buffer and the storage registers first, then issues the reset, so that the registers that are restored and the registers that are kept can be told apart at the read port.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL1  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_CTL2  = 6'h21;
  localparam logic [ADDR_W-1:0] OFS_CTL3  = 6'h22;
  localparam logic [ADDR_W-1:0] OFS_CTL4  = 6'h23;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_STA1  = 6'h25;
  localparam logic [ADDR_W-1:0] OFS_STA2  = 6'h26;
  localparam logic [ADDR_W-1:0] OFS_BINC  = 6'h29;
  localparam logic [ADDR_W-1:0] OFS_BMOD  = 6'h2A;
  localparam logic [ADDR_W-1:0] OFS_BCNT  = 6'h2B;
  localparam logic [ADDR_W-1:0] OFS_MSEC  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 6'h2D;

  // status bit positions that other logic decodes
  localparam int STA1_RXRDY = 9;
  localparam int STA1_TXRDY = 13;
  localparam int STA2_DRDY  = 0;
  localparam int TEST_RXEMP = 5;
  localparam int CTL1_TXEIE = 6;
  localparam int CTL1_RXIE  = 9;
  localparam int CTL1_TXIE  = 13;
  localparam int CTL2_SRST  = 0;
  localparam int CTL2_TXEN  = 2;
  localparam int RXD_VALID  = 15;

  localparam logic [DATA_W-1:0] STA1_W1C  = 16'h9DB0;
  localparam logic [DATA_W-1:0] STA2_W1C  = 16'hBDD6;
  localparam logic [DATA_W-1:0] STA1_INIT = 16'h6040;
  localparam logic [DATA_W-1:0] STA2_INIT = 16'h4028;
  localparam logic [DATA_W-1:0] TEST_INIT = 16'h0060;
  localparam logic [DATA_W-1:0] CTL3_INIT = 16'h0700;
  localparam logic [DATA_W-1:0] BCNT_INIT = 16'h0004;
  localparam logic [DATA_W-1:0] RXB_INIT  = 16'h4000;
  localparam logic [DATA_W-1:0] BRK_WORD  = 16'h0800;
  localparam logic [DATA_W-1:0] CTL1_BOOT = 16'h0001;
  localparam logic [DATA_W-1:0] CTL2_BOOT = 16'h0004;
endpackage

// File: rtl/urf_rx_hold.sv
module urf_rx_hold
  import uart_regfront_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          take,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_break,
  output logic          full,
  output logic [DW-1:0] hold
);
  logic accept;
  assign accept = (rx_valid || rx_break) && !full;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      full <= 1'b0;
      hold <= RXB_INIT;
    end else if (take && full) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      hold <= rx_break ? BRK_WORD : DW'(rx_byte);
    end
  end

  // R3: the buffer only fills from an offered event while it was empty
  a_r3_fill_from_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(rx_valid || rx_break));
  // R2: a read of a full buffer empties it
  a_r2_read_empties: assert property (@(posedge clk) disable iff (rst)
    (take && full) |=> !full);
  // R4: break wins over a simultaneous byte
  a_r4_break_word: assert property (@(posedge clk) disable iff (rst)
    (accept && rx_break && !soft_clr) |=> (hold == BRK_WORD));
endmodule

// File: rtl/urf_irq.sv
module urf_irq
  import uart_regfront_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sta1,
  input  logic [DW-1:0] ctl1,
  output logic          irq
);
  logic rx_term, tx_term;
  assign rx_term = sta1[STA1_RXRDY] & ctl1[CTL1_RXIE];
  assign tx_term = sta1[STA1_TXRDY] & ctl1[CTL1_TXIE] & ctl1[CTL1_TXEIE];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= rx_term | tx_term;
  end

  // R5: interrupt needs an enable in the prior cycle
  a_r5_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctl1[CTL1_RXIE] || (ctl1[CTL1_TXIE] && ctl1[CTL1_TXEIE])));
endmodule

// File: rtl/urf_tx.sv
module urf_tx
  import uart_regfront_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          enable,
  input  logic [BW-1:0] data,
  output logic          tx_valid,
  output logic [BW-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= hit && enable;
      if (hit && enable) tx_byte <= data;
    end
  end

  // R6: a strobe only follows an enabled transmit write
  a_r6_tx_gated: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(hit && enable));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_break,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [BW-1:0] tx_byte,
  output logic          irq
);
  logic [DW-1:0] ctl1_q, ctl2_q, ctl3_q, fifo_q, bmod_q, bcnt_q, msec_q;
  logic [DW-1:0] sta1_q, sta2_q, sta1, sta2, test_v, hold;
  logic          full, soft_rst, take;
  logic [DW-1:0] rd_next;

  assign soft_rst = wr_en && (wr_addr == OFS_CTL2) && !wr_data[CTL2_SRST];
  assign take     = rd_en && (rd_addr == OFS_RXD);

  // status views built from stored bits plus the buffer flag
  always_comb begin
    sta1 = sta1_q;
    sta1[STA1_RXRDY] = full;
    sta2 = sta2_q;
    sta2[STA2_DRDY] = full;
    test_v = TEST_INIT;
    test_v[TEST_RXEMP] = !full;
  end

  assign rx_ready = !full;

  urf_rx_hold #(.DW(DW), .BW(BW)) u_rx (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .take(take),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .full(full), .hold(hold)
  );

  urf_tx #(.BW(BW)) u_tx (
    .clk(clk), .rst(rst), .hit(wr_en && (wr_addr == OFS_TXD)),
    .enable(ctl2_q[CTL2_TXEN]), .data(wr_data[BW-1:0]),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  urf_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst(rst), .sta1(sta1), .ctl1(ctl1_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q <= CTL1_BOOT;
      ctl2_q <= CTL2_BOOT;
      ctl3_q <= CTL3_INIT;
      fifo_q <= '0;
      bmod_q <= '0;
      bcnt_q <= BCNT_INIT;
      msec_q <= '0;
      sta1_q <= STA1_INIT;
      sta2_q <= STA2_INIT;
    end else if (soft_rst) begin
      ctl1_q <= '0;
      ctl2_q <= wr_data | DW'(1);
      ctl3_q <= CTL3_INIT;
      bmod_q <= '0;
      bcnt_q <= BCNT_INIT;
      sta1_q <= STA1_INIT;
      sta2_q <= STA2_INIT;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_CTL1: ctl1_q <= wr_data;
        OFS_CTL2: ctl2_q <= wr_data;
        OFS_CTL3: ctl3_q <= wr_data;
        OFS_FIFO: fifo_q <= wr_data;
        OFS_BINC: bcnt_q <= wr_data;
        OFS_BMOD: bmod_q <= wr_data;
        OFS_MSEC: msec_q <= wr_data;
        OFS_STA1: sta1_q <= sta1_q & ~(wr_data & STA1_W1C);
        OFS_STA2: sta2_q <= sta2_q & ~(wr_data & STA2_W1C);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      OFS_RXD:  rd_next = full ? (hold | (DW'(1) << RXD_VALID)) : hold;
      OFS_CTL1: rd_next = ctl1_q;
      OFS_CTL2: rd_next = ctl2_q;
      OFS_CTL3: rd_next = ctl3_q;
      OFS_FIFO: rd_next = fifo_q;
      OFS_STA1: rd_next = sta1;
      OFS_STA2: rd_next = sta2;
      OFS_BMOD: rd_next = bmod_q;
      OFS_BCNT: rd_next = bcnt_q;
      OFS_MSEC: rd_next = msec_q;
      OFS_TEST: rd_next = test_v;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R8: soft reset forces the reset bit back to 1 and clears CR1
  a_r8_srst_forced: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ctl2_q[CTL2_SRST] && ctl1_q == '0 && !full));
  // R6: transmit-ready is never dropped
  a_r6_txrdy_held: assert property (@(posedge clk) disable iff (rst)
    sta1[STA1_TXRDY]);
  // R3: receive handshake mirrors the buffer flag in status
  a_r3_ready_mirror: assert property (@(posedge clk) disable iff (rst)
    rx_ready == !sta1[STA1_RXRDY] && sta2[STA2_DRDY] == sta1[STA1_RXRDY]);
endmodule

// File: tb/uart_regfront_tb_top.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en = 0, rd_en = 0, rx_valid = 0, rx_break = 0;
  logic [5:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [7:0]  rx_byte = 0;
  logic [15:0] rd_data;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_byte;
  int checks = 0, fails = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic brk);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_break = brk;
    @(negedge clk); rx_valid = 0; rx_break = 0;
  endtask

  task automatic t_reset_values;
    rdchk("R1 ctl1", 6'h20, 16'h0001);
    rdchk("R1 ctl2", 6'h21, 16'h0004);
    rdchk("R1 ctl3", 6'h22, 16'h0700);
    rdchk("R1 sta1", 6'h25, 16'h6040);
    rdchk("R1 sta2", 6'h26, 16'h4028);
    rdchk("R1 test", 6'h2D, 16'h0060);
    rdchk("R1 bmod", 6'h2A, 16'h0000);
    rdchk("R1 bcnt", 6'h2B, 16'h0004);
    rdchk("R1 fifo", 6'h24, 16'h0000);
    rdchk("R1 msec", 6'h2C, 16'h0000);
    rdchk("R1 rxd",  6'h00, 16'h4000);
    chk("R1 rx_ready", 16'(rx_ready), 16'h1);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_w1c;
    wr(6'h25, 16'hFFFF);
    rdchk("R7 sta1 unmasked kept", 6'h25, 16'h6040);
    wr(6'h26, 16'hFFFF);
    rdchk("R7 sta2 unmasked kept", 6'h26, 16'h4028);
  endtask

  task automatic t_storage;
    wr(6'h22, 16'hBEEF); rdchk("R9 ctl3", 6'h22, 16'hBEEF);
    wr(6'h24, 16'h1234); rdchk("R9 fifo", 6'h24, 16'h1234);
    wr(6'h2A, 16'h0A0B); rdchk("R9 bmod", 6'h2A, 16'h0A0B);
    wr(6'h2C, 16'h5566); rdchk("R9 msec", 6'h2C, 16'h5566);
    wr(6'h29, 16'h0321); rdchk("R9 bcnt via inc", 6'h2B, 16'h0321);
    rdchk("R9 inc reads 0", 6'h29, 16'h0000);
    wr(6'h23, 16'hFFFF); rdchk("R10 ctl4 reads 0", 6'h23, 16'h0000);
    wr(6'h2D, 16'h0000); rdchk("R10 test write dropped", 6'h2D, 16'h0060);
    rdchk("R10 unmapped", 6'h3F, 16'h0000);
  endtask

  task automatic t_tx;
    @(negedge clk); wr_en = 1; wr_addr = 6'h10; wr_data = 16'h01A5;
    @(negedge clk); wr_en = 0;
    chk("R6 tx_valid", 16'(tx_valid), 16'h1);
    chk("R6 tx_byte", 16'(tx_byte), 16'h00A5);
    @(negedge clk);
    chk("R6 tx_valid one cycle", 16'(tx_valid), 16'h0);
    rdchk("R6 txrdy held", 6'h25, 16'h6040);
    wr(6'h21, 16'h0001);
    @(negedge clk); wr_en = 1; wr_addr = 6'h10; wr_data = 16'h003C;
    @(negedge clk); wr_en = 0;
    chk("R6 tx disabled", 16'(tx_valid), 16'h0);
    wr(6'h21, 16'h0005);
  endtask

  task automatic t_rx;
    rx_send(8'h5A, 0);
    chk("R3 rx_ready low", 16'(rx_ready), 16'h0);
    rdchk("R3 sta1 full", 6'h25, 16'h6240);
    rdchk("R3 sta2 full", 6'h26, 16'h4029);
    rdchk("R3 test full", 6'h2D, 16'h0040);
    rx_send(8'h33, 0);
    rdchk("R2 rxd with valid", 6'h00, 16'h805A);
    rdchk("R2 sta1 emptied", 6'h25, 16'h6040);
    rdchk("R2 test emptied", 6'h2D, 16'h0060);
    rdchk("R3 second byte dropped", 6'h00, 16'h005A);
    chk("R3 rx_ready high", 16'(rx_ready), 16'h1);
  endtask

  task automatic t_break;
    rx_send(8'h00, 1);
    rdchk("R4 break word", 6'h00, 16'h8800);
    rx_send(8'h77, 1);
    rdchk("R4 break beats byte", 6'h00, 16'h8800);
  endtask

  task automatic t_irq;
    wr(6'h20, 16'h0200);
    @(negedge clk); chk("R5 idle no irq", 16'(irq), 16'h0);
    rx_send(8'h11, 0);
    @(negedge clk); chk("R5 rx irq", 16'(irq), 16'h1);
    begin logic [15:0] v; rd(6'h00, v); end
    @(negedge clk); chk("R5 rx irq cleared", 16'(irq), 16'h0);
    wr(6'h20, 16'h2000);
    @(negedge clk); chk("R5 tx term gated", 16'(irq), 16'h0);
    wr(6'h20, 16'h2040);
    @(negedge clk); chk("R5 tx irq", 16'(irq), 16'h1);
    wr(6'h20, 16'h0000);
  endtask

  task automatic t_soft_reset;
    wr(6'h24, 16'h1234);
    wr(6'h2C, 16'h4321);
    wr(6'h22, 16'hBEEF);
    wr(6'h20, 16'h0201);
    rx_send(8'h99, 0);
    wr(6'h21, 16'h0006);
    rdchk("R8 ctl2 srst forced", 6'h21, 16'h0007);
    rdchk("R8 ctl1 cleared", 6'h20, 16'h0000);
    rdchk("R8 ctl3 restored", 6'h22, 16'h0700);
    rdchk("R8 bcnt restored", 6'h2B, 16'h0004);
    rdchk("R8 sta1 restored", 6'h25, 16'h6040);
    rdchk("R8 test restored", 6'h2D, 16'h0060);
    rdchk("R8 rxd restored", 6'h00, 16'h4000);
    rdchk("R8 fifo kept", 6'h24, 16'h1234);
    rdchk("R8 msec kept", 6'h2C, 16'h4321);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    fork
      begin
        t_reset_values();
        t_w1c();
        t_storage();
        t_tx();
        t_rx();
        t_break();
        t_irq();
        t_soft_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule